// File: doc/BRIEF.md
# March Memory Test Sequencer

This block is a built-in self-test controller for a synchronous single-port RAM. After a start pulse it walks the whole address space through a selected March algorithm. Every write stores a data background that copies one bit into all bits of the word. Every read is checked against the value the algorithm expects. Two algorithms are available. The first is a twelve-operation March C- derivative that adds repeated reads and two low-supply pauses. The second is a shorter ten-operation sequence built around in-element write/read pairs.

Low-supply pauses are modelled as a request/acknowledge handshake with an external supply controller. The sequencer issues no memory access while the request is raised. A single-read option serves arrays whose read path already senses twice. In that mode each back-to-back repeat of the same read is issued once. On the first mismatch the sequencer records where the failure happened. It then either stops or carries on to the end, as configured.

Top module: `march_bist`

## Requirements
- R1: After reset, done_o, fail_o, busy_o, lps_req_o, mem_re_o and mem_we_o are all low.
- R2: With algo_sel_i=0 the elements run in this order: ascending W0; ascending R0 W1; ascending R1 W0; descending R0 W1; pause; descending R1 R1 W0; pause; ascending R0 R0. That is 12 operations per address.
- R3: With algo_sel_i=1 the elements run in this order: descending W0; pause; ascending R0 W0 W1 R1; pause; ascending R1 W1 W0 R0; descending R0. That is 10 operations per address.
- R4: With single_read_i=1, each read that directly repeats the previous read of the same value inside an element is not issued. This gives 10 operations per address for algo 0 and leaves algo 1 unchanged.
- R5: An element finishes all of its operations at one address before it moves to the next address. Ascending order runs 0 to DEPTH-1 and descending order runs DEPTH-1 to 0. Read enable and write enable are never high together.
- R6: A pause happens only between elements, and only when hold_en_i=1. lps_req_o rises and stays high until lps_ack_i is seen. It then stays high for max(hold_cycles_i,1) further cycles and falls. The next element starts only after lps_ack_i is low again. No memory access occurs while lps_req_o is high.
- R7: With hold_en_i=0 no pause occurs and lps_req_o stays low.
- R8: Every write drives mem_wdata_o with all bits equal to the written value: all zeros for W0 and all ones for W1.
- R9: A read compares mem_rdata_i in the cycle after mem_re_o against the expected value replicated across the word. The first mismatch sets fail_o. It also latches fail_addr_o, fail_elem_o (0-based element position in the R2/R3 order) and fail_op_o (0-based position among the operations issued in that element). All of these hold until the next start.
- R10: With stop_on_fail_i=1 the run ends at the first mismatch: done_o rises and no further memory operation is issued. With stop_on_fail_i=0 the run completes and the first failure record is kept.
- R11: busy_o is high during a run. done_o rises after the last read has been compared and stays high, with no memory or supply activity, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle or done |
| algo_sel_i | input | 1 | 0: extended March C-, 1: short sequence |
| single_read_i | input | 1 | Issue back-to-back repeated reads once |
| hold_en_i | input | 1 | Enable low-supply pauses |
| stop_on_fail_i | input | 1 | End the run at the first mismatch |
| hold_cycles_i | input | HOLD_W | Pause length in cycles (0 treated as 1) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after mem_re_o |
| lps_req_o | output | 1 | Low-supply request |
| lps_ack_i | input | 1 | Low-supply acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | A read mismatch was seen |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_elem_o | output | 3 | Element position of the first mismatch |
| fail_op_o | output | 2 | Operation position of the first mismatch |

## Verification
Each memory operation appears on the ports in the cycle it is issued. The bench samples the operation stream at falling edges and compares it, entry by entry, with a stream that bench functions compute from the algorithm tables. A read's verdict is due one cycle after its enable, so with stop-on-fail the captured stream must end exactly at the failing read. The request length is counted in falling edges with request and acknowledge both high, which is the configured length plus one. The final results are compared only once done_o is high and a few idle cycles have passed.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int unsigned ELEM_W = 3;
  localparam int unsigned OP_W   = 2;
  localparam int unsigned MAX_OPS = 4;

  typedef struct packed {
    logic is_wr;
    logic val;
  } mop_t;

  typedef struct packed {
    logic              down;
    logic              hold;
    logic [2:0]        nops;
    mop_t [MAX_OPS-1:0] ops;  // ops[0] runs first
  } melem_t;

  localparam mop_t OP_R0 = 2'b00;
  localparam mop_t OP_R1 = 2'b01;
  localparam mop_t OP_W0 = 2'b10;
  localparam mop_t OP_W1 = 2'b11;

  function automatic melem_t mk_elem(logic dn, logic hd, logic [2:0] n,
                                     mop_t a, mop_t b, mop_t c, mop_t d);
    melem_t e;
    e.down = dn;
    e.hold = hd;
    e.nops = n;
    e.ops  = {d, c, b, a};
    return e;
  endfunction
endpackage

// File: rtl/march_elem_rom.sv
module march_elem_rom
  import march_pkg::*;
(
  input  logic              algo_i,
  input  logic              single_read_i,
  input  logic [ELEM_W-1:0] idx_i,
  output melem_t            elem_o,
  output logic [ELEM_W-1:0] num_elem_o
);
  melem_t raw;

  always_comb begin
    raw = '0;
    if (!algo_i) begin
      num_elem_o = ELEM_W'(6);
      case (idx_i)
        3'd0: raw = mk_elem(1'b0, 1'b0, 3'd1, OP_W0, OP_R0, OP_R0, OP_R0);
        3'd1: raw = mk_elem(1'b0, 1'b0, 3'd2, OP_R0, OP_W1, OP_R0, OP_R0);
        3'd2: raw = mk_elem(1'b0, 1'b0, 3'd2, OP_R1, OP_W0, OP_R0, OP_R0);
        3'd3: raw = mk_elem(1'b1, 1'b0, 3'd2, OP_R0, OP_W1, OP_R0, OP_R0);
        3'd4: raw = mk_elem(1'b1, 1'b1, 3'd3, OP_R1, OP_R1, OP_W0, OP_R0);
        3'd5: raw = mk_elem(1'b0, 1'b1, 3'd2, OP_R0, OP_R0, OP_R0, OP_R0);
        default: raw = '0;
      endcase
    end else begin
      num_elem_o = ELEM_W'(4);
      case (idx_i)
        3'd0: raw = mk_elem(1'b1, 1'b0, 3'd1, OP_W0, OP_R0, OP_R0, OP_R0);
        3'd1: raw = mk_elem(1'b0, 1'b1, 3'd4, OP_R0, OP_W0, OP_W1, OP_R1);
        3'd2: raw = mk_elem(1'b0, 1'b1, 3'd4, OP_R1, OP_W1, OP_W0, OP_R0);
        3'd3: raw = mk_elem(1'b1, 1'b0, 3'd1, OP_R0, OP_R0, OP_R0, OP_R0);
        default: raw = '0;
      endcase
    end
  end

  // Drop reads that repeat the previous read when the array senses twice
  always_comb begin
    logic [2:0] j;
    elem_o      = '0;
    elem_o.down = raw.down;
    elem_o.hold = raw.hold;
    j = '0;
    for (int k = 0; k < MAX_OPS; k++) begin
      if (3'(k) < raw.nops) begin
        if (!(single_read_i && k > 0 && !raw.ops[k].is_wr && raw.ops[k] == raw.ops[k-1])) begin
          elem_o.ops[j[1:0]] = raw.ops[k];
          j = j + 3'd1;
        end
      end
    end
    elem_o.nops = j;
  end
endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              down_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);
  logic down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      addr_o <= down_i ? TOP : '0;
      down_q <= down_i;
    end else if (step_i) begin
      addr_o <= down_q ? addr_o - 1'b1 : addr_o + 1'b1;
    end
  end

  assign last_o = down_q ? (addr_o == '0) : (addr_o == TOP);
endmodule

// File: rtl/march_hold_ctrl.sv
module march_hold_ctrl #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] cycles_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              done_o
);
  typedef enum logic [1:0] {H_IDLE, H_REQ, H_CNT, H_REL} hst_e;
  hst_e st_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= H_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        H_IDLE: if (start_i) st_q <= H_REQ;
        H_REQ: if (ack_i) begin
          st_q  <= H_CNT;
          cnt_q <= (cycles_i == '0) ? HOLD_W'(1) : cycles_i;
        end
        H_CNT: if (cnt_q == HOLD_W'(1)) st_q <= H_REL;
               else cnt_q <= cnt_q - 1'b1;
        H_REL: if (!ack_i) st_q <= H_IDLE;
        default: st_q <= H_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == H_REQ) || (st_q == H_CNT);
  assign done_o = (st_q == H_REL) && !ack_i;
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 1 << ADDR_W,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              algo_sel_i,
  input  logic              single_read_i,
  input  logic              hold_en_i,
  input  logic              stop_on_fail_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              lps_req_o,
  input  logic              lps_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [2:0]        fail_elem_o,
  output logic [1:0]        fail_op_o
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HOLD, S_RUN, S_DRAIN, S_DONE} st_e;
  st_e st_q;

  logic algo_q, single_q, hold_en_q, stop_q;
  logic [ELEM_W-1:0] elem_q, num_elem;
  logic [OP_W-1:0]   op_q;
  melem_t            cur;
  mop_t              cur_op;
  logic              last_op, last_addr, at_end;
  logic              hold_start, hold_done, abort, mismatch, issue;
  logic              rd_pend_q, rd_exp_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [ELEM_W-1:0] rd_elem_q;
  logic [OP_W-1:0]   rd_op_q;
  logic              done_q, fail_q;

  march_elem_rom i_rom (
    .algo_i        (algo_q),
    .single_read_i (single_q),
    .idx_i         (elem_q),
    .elem_o        (cur),
    .num_elem_o    (num_elem)
  );

  assign cur_op   = cur.ops[op_q];
  assign last_op  = (op_q == OP_W'(cur.nops - 3'd1));
  assign at_end   = (elem_q == num_elem);
  assign mismatch = rd_pend_q && (mem_rdata_i != {DATA_W{rd_exp_q}});
  assign abort    = mismatch && stop_q;
  assign issue    = (st_q == S_RUN) && !abort;

  march_addr_gen #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st_q == S_SETUP),
    .down_i (cur.down),
    .step_i (issue && last_op && !last_addr),
    .addr_o (mem_addr_o),
    .last_o (last_addr)
  );

  assign hold_start = (st_q == S_SETUP) && !at_end && cur.hold && hold_en_q && !abort;

  march_hold_ctrl #(.HOLD_W(HOLD_W)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (hold_start),
    .cycles_i (hold_cycles_i),
    .ack_i    (lps_ack_i),
    .req_o    (lps_req_o),
    .done_o   (hold_done)
  );

  assign mem_we_o    = issue && cur_op.is_wr;
  assign mem_re_o    = issue && !cur_op.is_wr;
  assign mem_wdata_o = {DATA_W{cur_op.val}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      algo_q    <= 1'b0;
      single_q  <= 1'b0;
      hold_en_q <= 1'b0;
      stop_q    <= 1'b0;
      elem_q    <= '0;
      op_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: if (start_i) begin
          st_q      <= S_SETUP;
          algo_q    <= algo_sel_i;
          single_q  <= single_read_i;
          hold_en_q <= hold_en_i;
          stop_q    <= stop_on_fail_i;
          elem_q    <= '0;
          op_q      <= '0;
          done_q    <= 1'b0;
        end
        S_SETUP: begin
          op_q <= '0;
          if (at_end)          st_q <= S_DRAIN;
          else if (hold_start) st_q <= S_HOLD;
          else                 st_q <= S_RUN;
        end
        S_HOLD: if (hold_done) st_q <= S_RUN;
        S_RUN: if (!abort) begin
          if (last_op) begin
            op_q <= '0;
            if (last_addr) begin
              elem_q <= elem_q + 1'b1;
              st_q   <= S_SETUP;
            end
          end else begin
            op_q <= op_q + 1'b1;
          end
        end
        S_DRAIN: st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
      if (abort && st_q != S_IDLE && st_q != S_DONE) st_q <= S_DONE;
      if ((st_q == S_DRAIN) || (abort && st_q != S_IDLE && st_q != S_DONE)) done_q <= 1'b1;
    end
  end

  // Read verdict pipeline, one cycle behind the read enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_exp_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_elem_q <= '0;
      rd_op_q   <= '0;
    end else begin
      rd_pend_q <= mem_re_o;
      rd_exp_q  <= cur_op.val;
      rd_addr_q <= mem_addr_o;
      rd_elem_q <= elem_q;
      rd_op_q   <= op_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
      fail_op_o   <= '0;
    end else if (start_i && (st_q == S_IDLE || st_q == S_DONE)) begin
      fail_q      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
      fail_op_o   <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_o <= rd_addr_q;
      fail_elem_o <= rd_elem_q;
      fail_op_o   <= rd_op_q;
    end
  end

  assign fail_o = fail_q;
  assign done_o = done_q;
  assign busy_o = (st_q != S_IDLE) && (st_q != S_DONE);
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              lps_req_o,
  input logic              lps_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o)); // R5
  AST_QUIET_LOW_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lps_req_o |-> !(mem_re_o || mem_we_o)); // R6
  AST_REQ_WAITS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lps_req_o && !lps_ack_i) |=> lps_req_o); // R6
  AST_WDATA_REPLICATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1)); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(mem_re_o || mem_we_o || lps_req_o || busy_o)); // R11
  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R11
endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_wdata_o (mem_wdata_o),
  .lps_req_o   (lps_req_o),
  .lps_ack_i   (lps_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/test_march_bist.sv
`timescale 1ns/1ps
module test_march_bist;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int HOLD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, algo = 1'b0, sread = 1'b0, hen = 1'b0, stop = 1'b0;
  logic [HOLD_W-1:0] hcyc = '0;
  logic [ADDR_W-1:0] addr;
  logic we, re, req, busy, done, fail;
  logic ack = 1'b0;
  logic [DATA_W-1:0] wdata, rdata;
  logic [ADDR_W-1:0] f_addr_o;
  logic [2:0] f_elem_o;
  logic [1:0] f_op_o;

  always #5 clk = ~clk;

  march_bist #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W), .HOLD_W(HOLD_W)) i_march_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .algo_sel_i(algo),
    .single_read_i(sread), .hold_en_i(hen), .stop_on_fail_i(stop),
    .hold_cycles_i(hcyc), .mem_addr_o(addr), .mem_we_o(we), .mem_wdata_o(wdata),
    .mem_re_o(re), .mem_rdata_i(rdata), .lps_req_o(req), .lps_ack_i(ack),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_addr_o(f_addr_o),
    .fail_elem_o(f_elem_o), .fail_op_o(f_op_o));

  // RAM model with an optional stuck-at bit
  logic [DATA_W-1:0] ram [DEPTH];
  logic f_en = 1'b0, f_val = 1'b0;
  int   f_a = 0, f_b = 0;
  always_ff @(posedge clk) begin
    if (we) begin
      ram[addr] <= wdata;
      if (f_en && int'(addr) == f_a) ram[addr][f_b] <= f_val;
    end
    if (re) rdata <= ram[addr];
  end

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string req_tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // Supply controller model
  int ack_dly = 0;
  initial forever begin
    @(posedge clk); #1;
    if (req != ack) begin
      repeat (ack_dly) @(posedge clk);
      if (ack_dly != 0) #1;
      ack = req;
    end
  end

  // Port monitor
  int got_q[$];
  int hold_len_q[$];
  int hl = 0, wbad = 0;
  logic req_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req && !req_d) got_q.push_back(-1);
      if (req && ack) hl++;
      if (!req && req_d) begin hold_len_q.push_back(hl); hl = 0; end
      if (we) begin
        got_q.push_back((1 << 17) | (int'(wdata[0]) << 16) | int'(addr));
        if (wdata != {DATA_W{wdata[0]}}) wbad++;
      end
      if (re) got_q.push_back(int'(addr));
      req_d = req;
    end
  end

  // Expected operation stream, from the requirement tables
  int exp_q[$], exp_el[$], exp_op[$];
  task automatic build_exp(bit alg, bit sr, bit he);
    int ne;
    int dn[6], hd[6], n[6];
    int op[6][4]; // 0=R0 1=R1 2=W0 3=W1
    exp_q.delete(); exp_el.delete(); exp_op.delete();
    if (!alg) begin // R2
      ne = 6;
      dn = '{0,0,0,1,1,0}; hd = '{0,0,0,0,1,1}; n = '{1,2,2,2,3,2};
      op = '{'{2,0,0,0}, '{0,3,0,0}, '{1,2,0,0}, '{0,3,0,0}, '{1,1,2,0}, '{0,0,0,0}};
    end else begin // R3
      ne = 4;
      dn = '{1,0,0,1,0,0}; hd = '{0,1,1,0,0,0}; n = '{1,4,4,1,0,0};
      op = '{'{2,0,0,0}, '{0,2,3,1}, '{1,3,2,0}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}};
    end
    for (int e = 0; e < ne; e++) begin
      int kept[$];
      for (int k = 0; k < n[e]; k++)
        if (!(sr && k > 0 && op[e][k] < 2 && op[e][k] == op[e][k-1])) kept.push_back(op[e][k]); // R4
      if (hd[e] != 0 && he) begin exp_q.push_back(-1); exp_el.push_back(e); exp_op.push_back(-1); end
      for (int i = 0; i < DEPTH; i++) begin
        int a;
        a = (dn[e] != 0) ? DEPTH - 1 - i : i;
        for (int j = 0; j < kept.size(); j++) begin
          exp_q.push_back(((kept[j] >> 1) << 17) | ((kept[j] & 1) << 16) | a);
          exp_el.push_back(e); exp_op.push_back(j);
        end
      end
    end
  endtask

  task automatic run_one(bit alg, bit sr, bit he, bit st, int hc, bit fe, int fa, int fb, bit fv, int dly);
    int fidx, nexp, nhold, g, mism, last_n;
    f_en = fe; f_a = fa; f_b = fb; f_val = fv; ack_dly = dly;
    build_exp(alg, sr, he);
    fidx = -1;
    if (fe)
      for (int i = 0; i < exp_q.size(); i++)
        if (exp_q[i] >= 0 && ((exp_q[i] >> 17) & 1) == 0 && (exp_q[i] & 16'hffff) == fa &&
            ((exp_q[i] >> 16) & 1) != int'(fv)) begin fidx = i; break; end
    nexp = (st && fidx >= 0) ? fidx + 1 : exp_q.size();
    nhold = 0;
    for (int i = 0; i < nexp; i++) if (exp_q[i] < 0) nhold++;
    @(negedge clk);
    got_q.delete(); hold_len_q.delete(); wbad = 0;
    algo = alg; sread = sr; hen = he; stop = st; hcyc = HOLD_W'(hc); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R11 busy after start", int'(busy), 1);
    g = 0;
    while (!done && g < 5000) begin @(negedge clk); g++; end
    last_n = got_q.size();
    repeat (3) @(negedge clk);
    chk(done && got_q.size() == last_n, "R11 done held and quiet", got_q.size(), last_n);
    chk(got_q.size() == nexp, (st && fidx >= 0) ? "R10 stream length" : (sr ? "R4 stream length" : "R2/R3 stream length"), got_q.size(), nexp);
    mism = -1;
    for (int i = 0; i < nexp && i < got_q.size(); i++) begin
      int e;
      e = exp_q[i];
      if (e >= 0 && ((e >> 17) & 1) == 0) e = e & 32'h1ffff & ~(1 << 16);
      if (got_q[i] != e) begin mism = i; break; end
    end
    chk(mism < 0, alg ? "R3 R5 order" : "R2 R5 order", mism < 0 ? 0 : got_q[mism], mism < 0 ? 0 : exp_q[mism]);
    chk(hold_len_q.size() == nhold, he ? "R6 pause count" : "R7 no pause", hold_len_q.size(), nhold);
    foreach (hold_len_q[i])
      chk(hold_len_q[i] == ((hc == 0) ? 1 : hc) + 1, "R6 pause length", hold_len_q[i], ((hc == 0) ? 1 : hc) + 1);
    chk(wbad == 0, "R8 write data", wbad, 0);
    chk(fail == (fidx >= 0), "R9 fail flag", int'(fail), int'(fidx >= 0));
    if (fidx >= 0) begin
      chk(int'(f_addr_o) == fa, "R9 fail addr", int'(f_addr_o), fa);
      chk(int'(f_elem_o) == exp_el[fidx], "R9 fail elem", int'(f_elem_o), exp_el[fidx]);
      chk(int'(f_op_o) == exp_op[fidx], "R9 R12 fail op", int'(f_op_o), exp_op[fidx]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    chk(!done && !fail && !busy && !req && !re && !we, "R1 reset state",
        int'({done, fail, busy, req, re, we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_one(0, 0, 1, 0, 2, 0, 0, 0, 0, 0);   // R2 full with pauses
    run_one(1, 0, 1, 0, 3, 0, 0, 0, 0, 2);   // R3 delayed ack
    run_one(0, 1, 1, 0, 1, 0, 0, 0, 0, 1);   // R4 collapsed reads
    run_one(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);   // R4 R7 no pauses
    run_one(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);   // R6 zero length treated as one
    run_one(0, 0, 1, 1, 2, 1, 5, 3, 1, 0);   // R10 stop on fail
    run_one(1, 0, 1, 0, 1, 1, 15, 0, 0, 1);  // R10 continue, first record kept
    run_one(0, 1, 0, 1, 1, 1, 0, 7, 0, 0);   // R9 fail in single-read mode
    for (int r = 0; r < 12; r++)
      run_one($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
              $urandom_range(0, 1) != 0, $urandom_range(0, 4), $urandom_range(0, 2) != 0,
              $urandom_range(0, DEPTH - 1), $urandom_range(0, DATA_W - 1),
              $urandom_range(0, 1) != 0, $urandom_range(0, 3));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule